// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

A 32-pin general-purpose I/O port on a small memory-mapped register bus. Software sets per-pin output values and directions and reads back the synchronised pin levels. Each pin can also raise an interrupt. The trigger can be a level or an edge, and either polarity can be selected. Triggers are latched into a status register, and the port drives a single combined interrupt line.

Each writable register has three write addresses. A write to the base loads the whole register. A write to base+0x4 ORs the write data into the register. A write to base+0x8 clears every bit that is 1 in the write data. Software can therefore change single bits without a read-modify-write. A detection only reaches the status register when the pin's routing bit is set. A status bit only reaches the interrupt line when the pin's interrupt-enable bit is set.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `pad_oe` is 0.
- R2: For output data (0x000), output enable (0x400), routing (0x900), interrupt enable (0xA00), trigger mode (0xB00) and polarity (0xC00), a write to base+0x0 loads the register, base+0x4 ORs in the write data and base+0x8 clears the bits set in the write data. A read with `rd` high at any of these addresses returns the register on `rdata` one cycle later.
- R3: `pad_o` equals the output data register. `pad_oe` equals the output enable register, where a 1 drives the pin and a 0 leaves it high impedance.
- R4: The input register at 0x200 returns `pin_i` after a two-flop synchroniser. Writes to it have no effect.
- R5: With trigger mode bit 0 (edge), polarity 1 latches a status bit on a rising edge and polarity 0 latches it on a falling edge. The opposite edge latches nothing. An edge is the synchronised value differing from its value one cycle earlier.
- R6: With trigger mode bit 1 (level), the status bit is set on every cycle the pin sits at the polarity level (1 = high, 0 = low). A clear while the level persists leaves the bit set.
- R7: A pin whose routing bit is 0 never sets its status bit.
- R8: The status register (0xD00) changes only by detection or by a write of 1s to 0xD08. Writes to 0xD00 and 0xD04 are ignored. A detection and a clear of the same bit in the same cycle leave the bit set.
- R9: `irq` is 1 exactly when (status AND interrupt enable) is nonzero. It reflects the registered status and enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe; data appears the next cycle |
| rdata | output | 32 | Registered read data |
| pin_i | input | 32 | Asynchronous pin levels |
| pad_o | output | 32 | Per-pin output value |
| pad_oe | output | 32 | Per-pin drive enable (1 = drive) |
| irq | output | 1 | Combined port interrupt |

## Verification
The assertions assume that `wr` and `rd` strobes come with stable addresses that are sampled only at the clock edge. They also assume that `pin_i` may change at any cycle, because the synchroniser absorbs it. Status bits are assumed to fall only after a clear-alias write in the previous cycle. The stimulus drives every bus and pin input half a cycle away from the sampling edge. It holds each pin pattern for at least four cycles before status is read. Random register traffic runs with the pins held low, and a reset follows it before the directed interrupt scenarios.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    WOP_NONE = 2'd0,
    WOP_LOAD = 2'd1,
    WOP_SET  = 2'd2,
    WOP_CLR  = 2'd3
  } wop_e;

  localparam logic [7:0] OFS_LOAD = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;

  // index of each writable register in the generated bank
  localparam int IDX_OUT   = 0;
  localparam int IDX_OE    = 1;
  localparam int IDX_ROUTE = 2;
  localparam int IDX_IEN   = 3;
  localparam int IDX_LVL   = 4;
  localparam int IDX_POL   = 5;
  localparam int NWREG     = 6;

  function automatic wop_e op_of(input logic sel, input logic [7:0] low);
    if (!sel)                  return WOP_NONE;
    else if (low == OFS_LOAD)  return WOP_LOAD;
    else if (low == OFS_SET)   return WOP_SET;
    else if (low == OFS_CLR)   return WOP_CLR;
    else                       return WOP_NONE;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= din;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/gpio_wreg.sv
module gpio_wreg
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  wop_e         op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (op)
      WOP_LOAD: nxt = wdata;
      WOP_SET:  nxt = q | wdata;
      WOP_CLR:  nxt = q & ~wdata;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] route,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_nxt
);
  logic [W-1:0] prev;
  logic [W-1:0] rise, fall, edge_hit, lvl_hit, hit, clr_bits;

  always_comb begin
    rise     = cur & ~prev;
    fall     = ~cur & prev;
    edge_hit = (pol & rise) | (~pol & fall);
    lvl_hit  = ~(cur ^ pol);
    hit      = route & ((lvl & lvl_hit) | (~lvl & edge_hit));
    clr_bits = clr_en ? clr_mask : '0;
    // detection takes precedence over a same-cycle clear
    stat_nxt = (stat_q & ~clr_bits) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      stat_q <= '0;
    end else begin
      prev   <= cur;
      stat_q <= stat_nxt;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] BASE_OUT   = 12'h000,
  parameter logic [AW-1:0] BASE_IN    = 12'h200,
  parameter logic [AW-1:0] BASE_OE    = 12'h400,
  parameter logic [AW-1:0] BASE_ROUTE = 12'h900,
  parameter logic [AW-1:0] BASE_IEN   = 12'hA00,
  parameter logic [AW-1:0] BASE_LVL   = 12'hB00,
  parameter logic [AW-1:0] BASE_POL   = 12'hC00,
  parameter logic [AW-1:0] BASE_STAT  = 12'hD00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  input  logic            wr,
  input  logic            rd,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pad_o,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam int PW = AW - 8;
  localparam logic [AW-1:0] WBASE [NWREG] =
    '{BASE_OUT, BASE_OE, BASE_ROUTE, BASE_IEN, BASE_LVL, BASE_POL};

  logic [PW-1:0]   page;
  logic [7:0]      low;
  logic [NPIN-1:0] regs_q   [NWREG];
  logic [NPIN-1:0] regs_nxt [NWREG];
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] stat_q, stat_nxt;
  logic [NPIN-1:0] ien_q, route_q;
  logic            clr_en;

  assign page = addr[AW-1:8];
  assign low  = addr[7:0];

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_i), .dout(pin_s)
  );

  for (genvar g = 0; g < NWREG; g++) begin : g_reg
    wop_e op;
    assign op = op_of(wr && (page == WBASE[g][AW-1:8]), low);
    gpio_wreg #(.W(NPIN)) u_reg (
      .clk(clk), .rst(rst), .op(op), .wdata(wdata),
      .q(regs_q[g]), .nxt(regs_nxt[g])
    );
  end

  assign clr_en = (op_of(wr && (page == BASE_STAT[AW-1:8]), low) == WOP_CLR);

  gpio_irq_det #(.W(NPIN)) u_det (
    .clk(clk), .rst(rst), .cur(pin_s),
    .route(regs_q[IDX_ROUTE]), .lvl(regs_q[IDX_LVL]), .pol(regs_q[IDX_POL]),
    .clr_en(clr_en), .clr_mask(wdata),
    .stat_q(stat_q), .stat_nxt(stat_nxt)
  );

  assign ien_q   = regs_q[IDX_IEN];
  assign route_q = regs_q[IDX_ROUTE];
  assign pad_o   = regs_q[IDX_OUT];
  assign pad_oe  = regs_q[IDX_OE];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_nxt & regs_nxt[IDX_IEN]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= '0;
      if (page == BASE_IN[AW-1:8])   rdata <= pin_s;
      if (page == BASE_STAT[AW-1:8]) rdata <= stat_q;
      for (int i = 0; i < NWREG; i++)
        if (page == WBASE[i][AW-1:8]) rdata <= regs_q[i];
    end
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 12,
  parameter logic [AW-1:0] BASE_OE   = 12'h400,
  parameter logic [AW-1:0] BASE_STAT = 12'hD00
) (
  input logic            clk,
  input logic            rst,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [NPIN-1:0] wdata,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] ien,
  input logic [NPIN-1:0] route,
  input logic [NPIN-1:0] pad_oe,
  input logic            irq
);
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(stat & ien)));

  // R8
  stat_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(stat) & ~stat) != '0) |->
      ($past(wr) && $past(addr) == BASE_STAT + 12'h8)));

  // R7
  route_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(stat) & ~$past(route)) == '0));

  // R3
  oe_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == BASE_OE) |=> (pad_oe == $past(wdata)));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && stat == '0 && pad_oe == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NPIN(NPIN), .AW(AW), .BASE_OE(BASE_OE), .BASE_STAT(BASE_STAT)
) u_chk (
  .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
  .stat(stat_q), .ien(ien_q), .route(route_q), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata, pin_i = '0, pad_o, pad_oe;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [11:0] A_OUT = 12'h000, A_IN = 12'h200, A_OE = 12'h400,
    A_ROUTE = 12'h900, A_IEN = 12'hA00, A_LVL = 12'hB00, A_POL = 12'hC00,
    A_STAT = 12'hD00;
  localparam logic [11:0] WB [6] = '{A_OUT, A_OE, A_ROUTE, A_IEN, A_LVL, A_POL};

  always #2 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pin_i(pin_i), .pad_o(pad_o), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] model_apply(input logic [31:0] old,
      input logic [31:0] d, input int op);
    case (op)
      0: return d;
      1: return old | d;
      default: return old & ~d;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(negedge clk);
    pin_i = p;
    wait_n(4);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mdl [6];
    void'($urandom(32'h5eed1234));
    wait_n(3);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      bus_rd(WB[i], v); chk("R1 reg after reset", v, 32'h0);
    end
    bus_rd(A_STAT, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);

    // R2/R3 random alias traffic, pins held low
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    for (int it = 0; it < 150; it++) begin
      int idx = int'($urandom % 6);
      int op  = int'($urandom % 3);
      logic [31:0] d = $urandom;
      logic [11:0] ofs = (op == 0) ? 12'h0 : (op == 1) ? 12'h4 : 12'h8;
      bus_wr(WB[idx] + ofs, d);
      mdl[idx] = model_apply(mdl[idx], d, op);
      bus_rd(WB[idx] + 12'(4 * ($urandom % 3)), v);
      chk("R2 alias readback", v, mdl[idx]);
      chk("R3 pad_o", pad_o, mdl[0]);
      chk("R3 pad_oe", pad_oe, mdl[1]);
    end

    @(negedge clk); rst = 1'b1; wait_n(2); rst = 1'b0;

    // R3 directed
    bus_wr(A_OE, 32'hFFFF0000);
    bus_wr(A_OUT, 32'h12345678);
    chk("R3 pad_o directed", pad_o, 32'h12345678);
    chk("R3 pad_oe directed", pad_oe, 32'hFFFF0000);

    // R4 input register
    set_pins(32'hA5A50F0F);
    bus_rd(A_IN, v); chk("R4 input read", v, 32'hA5A50F0F);
    bus_wr(A_IN, 32'h0);
    bus_rd(A_IN, v); chk("R4 input write ignored", v, 32'hA5A50F0F);
    set_pins(32'h0);
    bus_wr(A_STAT + 12'h8, 32'hFFFFFFFF);

    // R5 rising edge on pin 3, R9 irq gating
    bus_wr(A_POL + 12'h4, 32'h8);
    bus_wr(A_ROUTE + 12'h4, 32'h8);
    set_pins(32'h8);
    bus_rd(A_STAT, v); chk("R5 rising latched", v, 32'h8);
    chk("R9 irq off without enable", {31'h0, irq}, 32'h0);
    bus_wr(A_IEN + 12'h4, 32'h8);
    chk("R9 irq on with enable", {31'h0, irq}, 32'h1);
    set_pins(32'h0);
    bus_wr(A_STAT + 12'h8, 32'h8);
    bus_rd(A_STAT, v); chk("R8 clear alias", v, 32'h0);
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // R5 falling edge on pin 5
    bus_wr(A_ROUTE + 12'h4, 32'h20);
    set_pins(32'h20);
    bus_rd(A_STAT, v); chk("R5 rising ignored in falling mode", v, 32'h0);
    set_pins(32'h0);
    bus_rd(A_STAT, v); chk("R5 falling latched", v, 32'h20);

    // R8 load and set writes to status are ignored
    bus_wr(A_STAT, 32'h0);
    bus_wr(A_STAT + 12'h4, 32'hFFFFFFFF);
    bus_rd(A_STAT, v); chk("R8 status load/set ignored", v, 32'h20);
    bus_wr(A_STAT + 12'h8, 32'h20);

    // R6 level high on pin 7
    bus_wr(A_LVL + 12'h4, 32'h80);
    bus_wr(A_POL + 12'h4, 32'h80);
    bus_wr(A_ROUTE + 12'h4, 32'h80);
    set_pins(32'h80);
    bus_rd(A_STAT, v); chk("R6 level high latched", v, 32'h80);
    bus_wr(A_STAT + 12'h8, 32'h80);
    bus_rd(A_STAT, v); chk("R6 clear while level active", v, 32'h80);
    set_pins(32'h0);
    bus_wr(A_STAT + 12'h8, 32'h80);
    bus_rd(A_STAT, v); chk("R6 clear after level gone", v, 32'h0);

    // R6 level low on pin 9 (pin already low)
    bus_wr(A_LVL + 12'h4, 32'h200);
    bus_wr(A_ROUTE + 12'h4, 32'h200);
    wait_n(2);
    bus_rd(A_STAT, v); chk("R6 level low latched", v, 32'h200);
    set_pins(32'h200);
    bus_wr(A_STAT + 12'h8, 32'h200);
    bus_rd(A_STAT, v); chk("R6 level low released", v, 32'h0);

    // R7 unrouted pin 12
    bus_wr(A_POL + 12'h4, 32'h1000);
    set_pins(32'h1200);
    bus_rd(A_STAT, v); chk("R7 unrouted edge ignored", v, 32'h0);
    chk("R9 irq quiet", {31'h0, irq}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule